// File: doc/BRIEF.md
# FIFO Threshold DMA Burst Trigger

This block decides when a DMA engine may open a bus burst that drains pixel data FIFOs. It watches the fill levels of three FIFOs, counted in DWORDs, and raises a burst request together with the index of the FIFO to drain. Each threshold is chosen by a 2-bit code. The FIFO storage and the bus master sit outside the block.

Two trigger rules are supported. In packed mode a single threshold is compared with the sum of all three fill levels, and the request always names FIFO 0. In planar mode the first FIFO has its own threshold code, and the second and third FIFOs share one code. When several planes are ready at once they are served in round-robin order. A FIFO enable bit gates everything: while it is low the FIFOs are told to flush and no request is raised. A separate DMA enable bit must also be high before any request appears.

Once raised, the request and its index stay put until the bus master strobes burst-done. The block then waits one idle cycle and evaluates the levels again.

Top module: `dma_burst_trigger`

## Requirements
- R1: The threshold codes map as follows: code 00 selects 4 DWORDs, 01 selects 8, 10 selects 16 and 11 selects 32. A level meets its threshold when it is greater than or equal to that value.
- R2: In packed mode (`planar_mode`=0), `req` rises at the clock edge after lvl0+lvl1+lvl2 reaches the threshold given by `code_packed`, and `req_fifo` is then 0. The sum is formed without overflow, so its maximum is 381.
- R3: In planar mode (`planar_mode`=1), FIFO 0 is compared against `code_plane0`. FIFO 1 and FIFO 2 are both compared against `code_plane12`. `req_fifo` gives the index of the FIFO that is ready (0, 1 or 2).
- R4: While `fifo_en` is 0, `flush` is 1. Any request drops at the next clock edge, and no request is raised for any level. While `fifo_en` is 1, `flush` is 0.
- R5: While `dma_en` is 0, no request is raised, and a pending request drops at the next clock edge.
- R6: Once `req` is 1, it stays 1 with `req_fifo` unchanged until a clock edge at which `burst_done` is 1. This holds even if the levels fall below threshold in the meantime.
- R7: At a clock edge where `req` and `burst_done` are both 1, `req` goes to 0 for at least one cycle. If a threshold is still met, `req` rises again at the following edge.
- R8: In planar mode, ready FIFOs are granted in round-robin order, starting with the index after the last FIFO whose burst completed. After reset, the first priority is FIFO 0.
- R9: During and right after reset, `req` is 0 and `req_fifo` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | FIFO enable; 0 flushes the FIFOs and blocks requests |
| dma_en | input | 1 | DMA enable; 0 blocks requests |
| planar_mode | input | 1 | 0 selects the packed rule, 1 selects the planar rule |
| code_packed | input | 2 | Threshold code for the combined level |
| code_plane0 | input | 2 | Threshold code for FIFO 0 in planar mode |
| code_plane12 | input | 2 | Shared threshold code for FIFOs 1 and 2 in planar mode |
| lvl0 | input | 7 | FIFO 0 fill level in DWORDs |
| lvl1 | input | 7 | FIFO 1 fill level in DWORDs |
| lvl2 | input | 7 | FIFO 2 fill level in DWORDs |
| burst_done | input | 1 | Strobe from the bus master: the current burst has finished |
| flush | output | 1 | Flush command to the FIFOs |
| req | output | 1 | Burst request |
| req_fifo | output | 2 | Index of the FIFO to drain |

## Verification
In packed mode, every code is tried with a total one below its threshold and a total exactly at it, with the total split across all three FIFOs. This separates a true sum from a single-level compare and catches an off-by-one. A total of 256 tells a full-width sum apart from one that wraps. In planar mode, FIFO 1 is given a level that meets the FIFO 0 threshold but not the shared one, which exposes a mix-up between the codes. Saturated levels on all planes, and then on only two, show whether the rotation resumes after the last served index. Levels that drop while a request is pending, and strobes that arrive while levels stay high, separate the hold rule from the one-cycle gap rule.

// File: rtl/dbt_pkg.sv
package dbt_pkg;
  typedef enum logic {
    MODE_PACKED = 1'b0,
    MODE_PLANAR = 1'b1
  } trig_mode_e;

  localparam int THR_W = 6;

  // 2-bit code to DWORD threshold: 4, 8, 16, 32
  function automatic logic [THR_W-1:0] code_to_dw(input logic [1:0] code);
    return THR_W'(4) << code;
  endfunction
endpackage

// File: rtl/dbt_thresh.sv
module dbt_thresh
  import dbt_pkg::*;
#(
  parameter int LVL_W    = 7,
  parameter int NUM_FIFO = 3
) (
  input  logic [LVL_W-1:0]    lvl [NUM_FIFO],
  input  logic [1:0]          code_packed,
  input  logic [1:0]          code_plane0,
  input  logic [1:0]          code_plane12,
  output logic                packed_hit,
  output logic [NUM_FIFO-1:0] plane_hit
);
  localparam int SUM_W = LVL_W + $clog2(NUM_FIFO);

  logic [SUM_W-1:0] lvl_sum;

  always_comb begin
    lvl_sum = '0;
    for (int i = 0; i < NUM_FIFO; i++) begin
      lvl_sum = lvl_sum + SUM_W'(lvl[i]);
    end
  end

  assign packed_hit = (lvl_sum >= SUM_W'(code_to_dw(code_packed)));

  genvar g;
  generate
    for (g = 0; g < NUM_FIFO; g++) begin : g_plane
      if (g == 0) begin : g_first
        assign plane_hit[g] = (SUM_W'(lvl[g]) >= SUM_W'(code_to_dw(code_plane0)));
      end else begin : g_shared
        assign plane_hit[g] = (SUM_W'(lvl[g]) >= SUM_W'(code_to_dw(code_plane12)));
      end
      always_comb begin
        AST_SUM_NO_OVERFLOW: assert (lvl_sum >= SUM_W'(lvl[g])); // R2
      end
    end
  endgenerate
endmodule

// File: rtl/dbt_arbiter.sv
module dbt_arbiter #(
  parameter int NUM_FIFO = 3,
  localparam int IDX_W   = (NUM_FIFO > 1) ? $clog2(NUM_FIFO) : 1
) (
  input  logic [NUM_FIFO-1:0] hit,
  input  logic [IDX_W-1:0]    last_idx,
  output logic                gnt_valid,
  output logic [IDX_W-1:0]    gnt_idx
);
  always_comb begin
    gnt_valid = 1'b0;
    gnt_idx   = '0;
    for (int k = 1; k <= NUM_FIFO; k++) begin
      int cand;
      cand = (int'(last_idx) + k) % NUM_FIFO;
      if (!gnt_valid && hit[cand]) begin
        gnt_valid = 1'b1;
        gnt_idx   = IDX_W'(cand);
      end
    end
  end

  always_comb begin
    AST_GRANT_IS_READY: assert (!gnt_valid || hit[gnt_idx]); // R8
    AST_GRANT_NOT_LOST: assert ((hit == '0) || gnt_valid);   // R8
  end
endmodule

// File: rtl/dma_burst_trigger.sv
module dma_burst_trigger
  import dbt_pkg::*;
#(
  parameter int LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic             dma_en,
  input  logic             planar_mode,
  input  logic [1:0]       code_packed,
  input  logic [1:0]       code_plane0,
  input  logic [1:0]       code_plane12,
  input  logic [LVL_W-1:0] lvl0,
  input  logic [LVL_W-1:0] lvl1,
  input  logic [LVL_W-1:0] lvl2,
  input  logic             burst_done,
  output logic             flush,
  output logic             req,
  output logic [1:0]       req_fifo
);
  localparam int NUM_FIFO = 3;
  localparam int IDX_W    = $clog2(NUM_FIFO);

  logic [LVL_W-1:0]    lvl_arr [NUM_FIFO];
  logic                packed_hit;
  logic [NUM_FIFO-1:0] plane_hit;
  logic                gnt_valid;
  logic [IDX_W-1:0]    gnt_idx;
  trig_mode_e          mode;
  logic                eval_en;

  logic             req_q, req_d;
  logic [IDX_W-1:0] sel_q, sel_d;
  logic [IDX_W-1:0] last_q, last_d;
  logic             req_ce, sel_ce, last_ce;

  assign lvl_arr[0] = lvl0;
  assign lvl_arr[1] = lvl1;
  assign lvl_arr[2] = lvl2;
  assign mode       = trig_mode_e'(planar_mode);
  assign eval_en    = fifo_en & dma_en;

  dbt_thresh #(.LVL_W(LVL_W), .NUM_FIFO(NUM_FIFO)) u_thresh (
    .lvl          (lvl_arr),
    .code_packed  (code_packed),
    .code_plane0  (code_plane0),
    .code_plane12 (code_plane12),
    .packed_hit   (packed_hit),
    .plane_hit    (plane_hit)
  );

  dbt_arbiter #(.NUM_FIFO(NUM_FIFO)) u_arb (
    .hit       (plane_hit),
    .last_idx  (last_q),
    .gnt_valid (gnt_valid),
    .gnt_idx   (gnt_idx)
  );

  // next-state
  always_comb begin
    req_d  = req_q;
    sel_d  = sel_q;
    last_d = last_q;
    if (!eval_en) begin
      req_d = 1'b0;
    end else if (req_q) begin
      if (burst_done) begin
        req_d = 1'b0;
        if (mode == MODE_PLANAR) last_d = sel_q;
      end
    end else if (mode == MODE_PLANAR) begin
      if (gnt_valid) begin
        req_d = 1'b1;
        sel_d = gnt_idx;
      end
    end else if (packed_hit) begin
      req_d = 1'b1;
      sel_d = '0;
    end
  end

  assign req_ce  = (req_d != req_q);
  assign sel_ce  = req_d & ~req_q;
  assign last_ce = req_q & burst_done & eval_en & (mode == MODE_PLANAR);

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      sel_q  <= '0;
      last_q <= IDX_W'(NUM_FIFO - 1);
    end else begin
      if (req_ce)  req_q  <= req_d;
      if (sel_ce)  sel_q  <= sel_d;
      if (last_ce) last_q <= last_d;
    end
  end

  assign flush    = ~fifo_en;
  assign req      = req_q;
  assign req_fifo = 2'(sel_q);

  AST_FLUSH_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |=> !req_q); // R4
  AST_DMA_GATES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |=> !req_q); // R5
  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !burst_done && eval_en) |=> (req_q && $stable(sel_q))); // R6
  AST_DONE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && burst_done) |=> !req_q); // R7
  AST_PACKED_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_q && eval_en && !planar_mode) |=> (!req_q || sel_q == '0)); // R2
endmodule

// File: tb/dma_burst_trigger_tb.sv
`timescale 1ns/1ps
module dma_burst_trigger_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       fifo_en, dma_en, planar_mode, burst_done;
  logic [1:0] code_packed, code_plane0, code_plane12;
  logic [6:0] lvl0, lvl1, lvl2;
  logic       flush, req;
  logic [1:0] req_fifo;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  always #2.5 clk = ~clk;

  dma_burst_trigger u_dut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .dma_en(dma_en),
    .planar_mode(planar_mode), .code_packed(code_packed),
    .code_plane0(code_plane0), .code_plane12(code_plane12),
    .lvl0(lvl0), .lvl1(lvl1), .lvl2(lvl2), .burst_done(burst_done),
    .flush(flush), .req(req), .req_fifo(req_fifo)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic exp_req, input logic [1:0] exp_idx,
                     input bit use_idx);
    checks++;
    if (req !== exp_req || (use_idx && req_fifo !== exp_idx)) begin
      errors++;
      $display("FAIL %s: req=%b req_fifo=%0d expected req=%b req_fifo=%0d",
               tag, req, req_fifo, exp_req, exp_idx);
    end
  endtask

  task automatic chk_flush(input string tag, input logic exp);
    checks++;
    if (flush !== exp) begin
      errors++;
      $display("FAIL %s: flush=%b expected %b", tag, flush, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    fifo_en = 0; dma_en = 0; planar_mode = 0; burst_done = 0;
    code_packed = 0; code_plane0 = 0; code_plane12 = 0;
    lvl0 = 0; lvl1 = 0; lvl2 = 0;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic pulse_done();
    burst_done = 1'b1;
    step(1);
    burst_done = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R9 reset req", 1'b0, 2'd0, 1'b1);
    chk_flush("R4 flush while fifo_en=0", 1'b1);
  endtask

  task automatic t_packed();
    do_reset();
    fifo_en = 1; dma_en = 1; planar_mode = 0;
    step(1);
    chk_flush("R4 flush released", 1'b0);
    for (int c = 0; c < 4; c++) begin
      int thr;
      thr = 4 << c;
      code_packed = 2'(c);
      lvl0 = 7'(thr / 2); lvl1 = 7'(thr / 4); lvl2 = 7'(thr - thr / 2 - thr / 4 - 1);
      step(1);
      chk($sformatf("R1 R2 code %0d sum=thr-1", c), 1'b0, 2'd0, 1'b0);
      lvl2 = lvl2 + 7'd1;
      step(1);
      chk($sformatf("R1 R2 code %0d sum=thr", c), 1'b1, 2'd0, 1'b1);
      lvl0 = 0; lvl1 = 0; lvl2 = 0;
      pulse_done();
      chk("R7 req cleared by done", 1'b0, 2'd0, 1'b0);
    end
    code_packed = 2'b11;
    lvl0 = 7'd127; lvl1 = 7'd127; lvl2 = 7'd2;
    step(1);
    chk("R2 sum 256 no overflow", 1'b1, 2'd0, 1'b1);
    lvl0 = 0; lvl1 = 0; lvl2 = 0;
    step(3);
    chk("R6 req held after levels drop", 1'b1, 2'd0, 1'b1);
    lvl0 = 7'd40;
    pulse_done();
    chk("R7 gap after done", 1'b0, 2'd0, 1'b0);
    step(1);
    chk("R7 re-raised after gap", 1'b1, 2'd0, 1'b1);
  endtask

  task automatic t_planar();
    do_reset();
    fifo_en = 1; dma_en = 1; planar_mode = 1;
    code_plane0 = 2'b00; code_plane12 = 2'b11; code_packed = 2'b00;
    lvl0 = 7'd3; lvl1 = 7'd31; lvl2 = 7'd31;
    step(2);
    chk("R3 all below own thresholds", 1'b0, 2'd0, 1'b0);
    lvl1 = 7'd16; lvl2 = 7'd0;
    step(2);
    chk("R3 fifo1 uses shared code", 1'b0, 2'd0, 1'b0);
    lvl0 = 7'd4; lvl1 = 7'd0;
    step(1);
    chk("R3 fifo0 at 4", 1'b1, 2'd0, 1'b1);
    lvl0 = 7'd0;
    step(2);
    chk("R6 index held", 1'b1, 2'd0, 1'b1);
    lvl2 = 7'd32;
    pulse_done();
    step(1);
    chk("R3 fifo2 at 32", 1'b1, 2'd2, 1'b1);
  endtask

  task automatic t_round_robin();
    do_reset();
    fifo_en = 1; dma_en = 1; planar_mode = 1;
    code_plane0 = 2'b00; code_plane12 = 2'b00;
    lvl0 = 7'd100; lvl1 = 7'd100; lvl2 = 7'd100;
    step(1);
    chk("R8 first grant fifo0", 1'b1, 2'd0, 1'b1);
    pulse_done(); step(1);
    chk("R8 then fifo1", 1'b1, 2'd1, 1'b1);
    pulse_done(); step(1);
    chk("R8 then fifo2", 1'b1, 2'd2, 1'b1);
    pulse_done(); step(1);
    chk("R8 wrap to fifo0", 1'b1, 2'd0, 1'b1);
    lvl1 = 7'd0;
    pulse_done(); step(1);
    chk("R8 skip idle fifo1", 1'b1, 2'd2, 1'b1);
    pulse_done(); step(1);
    chk("R8 back to fifo0", 1'b1, 2'd0, 1'b1);
  endtask

  task automatic t_enables();
    do_reset();
    fifo_en = 1; dma_en = 1; planar_mode = 0; code_packed = 0;
    lvl0 = 7'd50;
    step(1);
    chk("R4 precondition req", 1'b1, 2'd0, 1'b1);
    fifo_en = 0;
    step(1);
    chk("R4 req dropped by flush", 1'b0, 2'd0, 1'b0);
    chk_flush("R4 flush asserted", 1'b1);
    step(3);
    chk("R4 no req while flushed", 1'b0, 2'd0, 1'b0);
    fifo_en = 1;
    step(1);
    chk("R4 req after enable", 1'b1, 2'd0, 1'b1);
    dma_en = 0;
    step(1);
    chk("R5 req dropped by dma_en", 1'b0, 2'd0, 1'b0);
    planar_mode = 1;
    step(3);
    chk("R5 no req while dma off", 1'b0, 2'd0, 1'b0);
  endtask

  initial begin
    t_reset();
    t_packed();
    t_planar();
    t_round_robin();
    t_enables();
    done_flag = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule